// File: doc/BRIEF.md
# Quadrature Sine/Cosine Table Generator

This block produces a pair of digital sinusoids, a sine and a cosine of the same frequency, for use as the carrier of a set of modulators and the reference of a set of coherent demodulators. A wide phase accumulator advances by a programmable tuning word on every enabled clock. Only its upper bits address the waveform table, so the output frequency is `f_clk * freq_inc / 2^PH_W` and can be set in fine steps.

The table stores a single quarter of a sine cycle as 17-bit magnitudes. The two bits just above the table index pick the quadrant. One bit makes the address count backwards through the table, which mirrors the quarter wave. The other bit negates the result in two's complement for the second half cycle. The table has two read ports. The cosine port reads the same phase advanced by one quarter cycle, with its own mirror and negate decode, so both outputs come from one stored quarter wave in the same cycle.

Each enabled cycle yields one sample pair three clocks later, flagged by `valid_o`. The default table depth is 1024 quarter-wave entries (`TBL_AW = 10`). Setting `TBL_AW = 14` gives the 16384-entry table with 18-bit output samples.

Top module: `quad_wave_gen`

## Requirements
- R1: While `rst` is high at a clock edge, the phase is cleared to zero, and after that edge `valid_o` is 0 and both `sin_o` and `cos_o` read 0.
- R2: On each clock edge with `en` high and `rst` low, the phase becomes phase + `freq_inc` modulo 2^44 (44 = 32 fraction bits + 10 index bits + 2 quadrant bits). Carries out of the fraction reach the table index.
- R3: On a clock edge with `en` low, the phase keeps its value and no sample pair is produced. When `en` returns high, output continues from the held phase without a skipped or repeated sample.
- R4: The first sample pair after reset is `sin_o` = 0 and `cos_o` = +131071.
- R5: With k = phase[43:32] (12 bits, N = 1024), `sin_o` is within one LSB of round(131071 * sin(2*pi*k / 4096)), as a signed 18-bit two's-complement value.
- R6: `cos_o` is within one LSB of round(131071 * sin(2*pi*((k + 1024) mod 4096) / 4096)), the same phase advanced by a quarter cycle.
- R7: The sample pair for the phase held before an enabled edge appears on the outputs after the third clock edge from that one, with `valid_o` high. Pairs arrive in the order of their enabled cycles, and `valid_o` is never high otherwise.
- R8: At the quadrant boundaries k = 0, 1024, 2048 and 3072 the sine is exactly 0, +131071, 0 and -131071, and the cosine is exact at the same points. Neither output ever reads -131072.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Advance the phase and emit one sample pair this cycle |
| freq_inc | input | 44 | Phase tuning word added per enabled cycle |
| sin_o | output | 18 | Signed sine sample |
| cos_o | output | 18 | Signed cosine sample |
| valid_o | output | 1 | Sample pair on the outputs is new this cycle |

## Verification
The hardest cases to reach from the ports are the four exact quadrant boundaries. The mirrored read there falls one entry past the stored quarter wave, and an off-by-one in the mirror arithmetic shows only at those few phases. The stimulus reaches them with a tuning word of exactly one index step and a zero fraction, which walks k through all 4096 phases including every boundary. Fractional tuning words, a negative word that runs the phase backwards through the wrap, and an irregular enable pattern then cover fraction carries, the reverse-counting direction and held phase.

// File: rtl/qsg_pkg.sv
`timescale 1ns/1ps
package qsg_pkg;
    localparam int QSG_SAMP_W = 18;
    localparam int QSG_TBL_AW = 10;
    localparam int QSG_FRAC_W = 32;

    // Per-port quadrant decode carried down the pipeline
    typedef struct packed {
        logic neg;   // second half cycle: negate the magnitude
        logic peak;  // mirrored read at index zero: full-scale magnitude
    } fold_t;
endpackage

// File: rtl/qsg_phase_acc.sv
`timescale 1ns/1ps
module qsg_phase_acc #(
    parameter int PH_W = 44,
    parameter int KW   = 12
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            en,
    input  logic [PH_W-1:0] inc,
    output logic [KW-1:0]   ph_top
);
    logic [PH_W-1:0] phase;

    always_ff @(posedge clk) begin
        if (rst)
            phase <= '0;
        else if (en)
            phase <= phase + inc;
    end

    assign ph_top = phase[PH_W-1 -: KW];

    p_phase_step_r2: assert property (@(posedge clk) disable iff (rst)
        en |=> (phase == $past(phase) + $past(inc)));

    p_phase_hold_r3: assert property (@(posedge clk) disable iff (rst)
        !en |=> $stable(phase));
endmodule

// File: rtl/qsg_fold.sv
`timescale 1ns/1ps
module qsg_fold
    import qsg_pkg::*;
#(
    parameter int AW = 10
) (
    input  logic [AW+1:0] k,
    output logic [AW-1:0] addr,
    output fold_t         flags
);
    logic [AW-1:0] idx;
    logic          mirror;

    assign idx    = k[AW-1:0];
    assign mirror = k[AW];

    always_comb begin
        flags.neg  = k[AW+1];
        flags.peak = mirror && (idx == '0);
        // counting down: N - idx, which wraps to 0 at the peak
        addr       = mirror ? (~idx + AW'(1)) : idx;
    end
endmodule

// File: rtl/qsg_rom.sv
`timescale 1ns/1ps
module qsg_rom #(
    parameter int AW = 10,
    parameter int MW = 17
) (
    input  logic          clk,
    input  logic [AW-1:0] addr [2],
    output logic [MW-1:0] data [2]
);
    localparam int  DEPTH = 1 << AW;
    localparam real HALF_PI = 1.5707963267948966;

    logic [MW-1:0] tbl [DEPTH];

    // quarter wave: entry i holds round(FS * sin(pi/2 * i / DEPTH))
    initial begin
        for (int i = 0; i < DEPTH; i++) begin
            tbl[i] = MW'($rtoi(real'((1 << MW) - 1)
                               * $sin(HALF_PI * real'(i) / real'(DEPTH)) + 0.5));
        end
    end

    always_ff @(posedge clk) begin
        for (int p = 0; p < 2; p++)
            data[p] <= tbl[addr[p]];
    end
endmodule

// File: rtl/qsg_unfold.sv
`timescale 1ns/1ps
module qsg_unfold
    import qsg_pkg::*;
#(
    parameter int SW = 18
) (
    input  logic [SW-2:0]        mag_in,
    input  fold_t                flags,
    output logic signed [SW-1:0] smp
);
    logic [SW-2:0]        mag;
    logic signed [SW-1:0] pos;

    assign mag = flags.peak ? {(SW-1){1'b1}} : mag_in;
    assign pos = $signed({1'b0, mag});
    assign smp = flags.neg ? -pos : pos;
endmodule

// File: rtl/quad_wave_gen.sv
`timescale 1ns/1ps
module quad_wave_gen
    import qsg_pkg::*;
#(
    parameter int SAMP_W = QSG_SAMP_W,
    parameter int TBL_AW = QSG_TBL_AW,
    parameter int FRAC_W = QSG_FRAC_W,
    localparam int PH_W  = FRAC_W + TBL_AW + 2
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     en,
    input  logic [PH_W-1:0]          freq_inc,
    output logic signed [SAMP_W-1:0] sin_o,
    output logic signed [SAMP_W-1:0] cos_o,
    output logic                     valid_o
);
    localparam int KW  = TBL_AW + 2;
    localparam int MW  = SAMP_W - 1;
    localparam int QTR = 1 << TBL_AW;

    logic [KW-1:0]        k_base;
    logic [TBL_AW-1:0]    addr_c [2];
    logic [TBL_AW-1:0]    addr_q [2];
    fold_t                flags_c [2];
    fold_t                f1_q [2];
    fold_t                f2_q [2];
    logic [MW-1:0]        mag [2];
    logic signed [SAMP_W-1:0] smp_c [2];
    logic                 v1_q, v2_q;

    qsg_phase_acc #(.PH_W(PH_W), .KW(KW)) u_acc (
        .clk    (clk),
        .rst    (rst),
        .en     (en),
        .inc    (freq_inc),
        .ph_top (k_base)
    );

    // Port 0 reads the phase as is (sine); port 1 a quarter cycle ahead (cosine)
    generate
        for (genvar ch = 0; ch < 2; ch++) begin : g_port
            logic [KW-1:0] k_ch;
            assign k_ch = k_base + KW'(ch * QTR);

            qsg_fold #(.AW(TBL_AW)) u_fold (
                .k     (k_ch),
                .addr  (addr_c[ch]),
                .flags (flags_c[ch])
            );

            qsg_unfold #(.SW(SAMP_W)) u_unfold (
                .mag_in (mag[ch]),
                .flags  (f2_q[ch]),
                .smp    (smp_c[ch])
            );
        end
    endgenerate

    // Stage 1: registered address and quadrant decode
    always_ff @(posedge clk) begin
        if (rst) begin
            v1_q <= 1'b0;
            for (int p = 0; p < 2; p++) begin
                addr_q[p] <= '0;
                f1_q[p]   <= '0;
            end
        end else begin
            v1_q   <= en;
            addr_q <= addr_c;
            f1_q   <= flags_c;
        end
    end

    // Stage 2: table read (registered inside the table)
    qsg_rom #(.AW(TBL_AW), .MW(MW)) u_rom (
        .clk  (clk),
        .addr (addr_q),
        .data (mag)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            v2_q <= 1'b0;
            for (int p = 0; p < 2; p++)
                f2_q[p] <= '0;
        end else begin
            v2_q <= v1_q;
            f2_q <= f1_q;
        end
    end

    // Stage 3: sign restored, outputs registered
    always_ff @(posedge clk) begin
        if (rst) begin
            sin_o   <= '0;
            cos_o   <= '0;
            valid_o <= 1'b0;
        end else begin
            sin_o   <= smp_c[0];
            cos_o   <= smp_c[1];
            valid_o <= v2_q;
        end
    end

    p_valid_rise_r7: assert property (@(posedge clk) disable iff (rst)
        v2_q |=> valid_o);

    p_valid_drop_r7: assert property (@(posedge clk) disable iff (rst)
        !v2_q |=> !valid_o);

    p_no_min_r8: assert property (@(posedge clk) disable iff (rst)
        valid_o |-> (sin_o != {1'b1, {(SAMP_W-1){1'b0}}})
                 && (cos_o != {1'b1, {(SAMP_W-1){1'b0}}}));
endmodule

// File: tb/quad_wave_gen_test.sv
`timescale 1ns/1ps
module quad_wave_gen_test;
    localparam int TBL_AW = 10;
    localparam int FRAC_W = 32;
    localparam int SAMP_W = 18;
    localparam int PH_W   = FRAC_W + TBL_AW + 2;
    localparam int KW     = TBL_AW + 2;
    localparam int N      = 1 << TBL_AW;
    localparam int FS     = (1 << (SAMP_W - 1)) - 1;
    localparam real PI    = 3.141592653589793;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic en  = 1'b0;
    logic [PH_W-1:0] freq_inc = '0;
    logic signed [SAMP_W-1:0] sin_o, cos_o;
    logic valid_o;

    always #10 clk = ~clk;

    quad_wave_gen #(.SAMP_W(SAMP_W), .TBL_AW(TBL_AW), .FRAC_W(FRAC_W)) uut (
        .clk      (clk),
        .rst      (rst),
        .en       (en),
        .freq_inc (freq_inc),
        .sin_o    (sin_o),
        .cos_o    (cos_o),
        .valid_o  (valid_o)
    );

    int n_chk = 0;
    int n_bad = 0;
    int cyc   = 0;
    always @(posedge clk) cyc <= cyc + 1;

    logic [PH_W-1:0] model_ph = '0;
    bit first_pending = 1'b0;
    int q_s[$];
    int q_c[$];
    int q_t[$];
    int q_k[$];
    bit q_f[$];

    function automatic int ideal(input int k);
        real x;
        x = real'(FS) * $sin(2.0 * PI * real'(k) / real'(4 * N));
        return (x >= 0.0) ? $rtoi(x + 0.5) : -$rtoi(-x + 0.5);
    endfunction

    task automatic check_val(input string tag, input int act, input int exp, input int tol);
        n_chk++;
        if (act - exp > tol || exp - act > tol) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // Scoreboard monitor: pops one expected pair per valid output
    always @(negedge clk) begin
        if (!rst && valid_o) begin
            if (q_s.size() == 0) begin
                n_chk++;
                n_bad++;
                $display("FAIL R7: actual valid_o=1 with nothing pending, expected 0");
            end else begin
                int es, ec, et, ek;
                bit ef;
                string ts, tc;
                es = q_s.pop_front();
                ec = q_c.pop_front();
                et = q_t.pop_front();
                ek = q_k.pop_front();
                ef = q_f.pop_front();
                ts = ef ? "R4" : ((ek % N == 0) ? "R8" : "R5");
                tc = ef ? "R4" : ((ek % N == 0) ? "R8" : "R6");
                check_val(ts, int'(sin_o), es, (ef || ek % N == 0) ? 0 : 1);
                check_val(tc, int'(cos_o), ec, (ef || ek % N == 0) ? 0 : 1);
                check_val("R7 latency", cyc, et + 3, 0);
            end
        end
    end

    // Driver: one cycle of stimulus; an enabled cycle pushes its expected pair
    task automatic step(input bit e, input logic [PH_W-1:0] inc);
        @(negedge clk);
        en = e;
        freq_inc = inc;
        if (e) begin
            int k;
            k = int'(model_ph[PH_W-1 -: KW]);
            q_s.push_back(ideal(k));
            q_c.push_back(ideal((k + N) % (4 * N)));
            q_t.push_back(cyc);
            q_k.push_back(k);
            q_f.push_back(first_pending);
            first_pending = 1'b0;
            model_ph = model_ph + inc;
        end
    endtask

    task automatic do_reset();
        repeat (4) step(1'b0, '0);
        @(negedge clk);
        rst = 1'b1;
        en  = 1'b0;
        repeat (2) @(negedge clk);
        check_val("R1 valid", int'(valid_o), 0, 0);
        check_val("R1 sin", int'(sin_o), 0, 0);
        check_val("R1 cos", int'(cos_o), 0, 0);
        rst = 1'b0;
        model_ph = '0;
        first_pending = 1'b1;
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    endtask

    initial begin
        do_reset();

        // R5/R6/R8: unit index step walks every phase, including all boundaries
        for (int i = 0; i < 4100; i++)
            step(1'b1, {12'd1, 32'h0000_0000});

        // R2: fractional tuning word, carries from the fraction
        for (int i = 0; i < 600; i++)
            step(1'b1, {12'd37, 32'h9E37_79B9});

        // R3: irregular enable pattern, phase must hold across gaps
        for (int i = 0; i < 400; i++)
            step(!((i % 3) == 1 || (i % 7) == 0), {12'd5, 32'h0000_0007});

        // R3: idle cycles produce nothing
        repeat (5) step(1'b0, '0);
        check_val("R3 idle valid", int'(valid_o), 0, 0);

        // R2: negative word runs the phase backwards through the wrap
        for (int i = 0; i < 400; i++)
            step(1'b1, '0 - {12'd3, 32'h0000_1234});

        // R1/R4: reset from a running state, then restart
        do_reset();
        for (int i = 0; i < 20; i++)
            step(1'b1, {12'd11, 32'h0000_0000});
        repeat (6) step(1'b0, '0);

        // R7: every expected pair came out
        check_val("R7 pending", q_s.size(), 0, 0);

        summary();
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end
endmodule